// File: doc/BRIEF.md
# Paged Register Map Decoder

This block sits between a two-wire serial slave front end and the byte storage of a module controller. The front end hands over each received device-address byte, each byte-address byte and one strobe per data byte read or written. The block decides whether the device address is one it answers to, keeps the byte pointer, and turns every access into a one-hot chip select with a local byte offset into the right storage region. When nothing answers at the pointer, it returns a fixed pattern instead.

The main device has a lower page that is always visible. Its upper half shows one of several tables, chosen by a table-select byte that the block holds itself. An alarm-enable row of eight bytes is placed in one of two tables by a configuration bit. A second, auxiliary device gives a flat 256-byte window with no paging. The main device answers at a fixed default address, or at an address taken from a configuration register when the address-select bit is set.

Top module: `paged_map_decoder`

## Requirements
- R1: With the main device selected, pointer values 00h–7Eh assert the lower-memory select (mem_cs bit 0), with an offset equal to the pointer, whatever table is selected.
- R2: Pointer 7Fh on the main device is the table-select byte. It resets to 01h, a write loads it from wr_data, a read returns it on rd_data, and neither asserts any mem_cs bit or mem_we.
- R3: With the main device selected and pointer 80h–FFh, the table-select byte picks the region and the offset is pointer minus 80h. Table 01h 80h–F7h is bit 2. Table 02h 80h–FFh is bit 4. Table 04h 80h–C7h is bit 5. Tables 06h, 07h and 08h at 80h–A3h are bits 6, 7 and 8.
- R4: The alarm-enable row (mem_cs bit 3, offset = pointer minus F8h) covers F8h–FFh of table 01h when cfg_mask is 0, and of table 05h when cfg_mask is 1. The other table has no mapping at F8h–FFh.
- R5: An access to an unmapped pointer asserts no mem_cs bit and no mem_we, and a read of it returns FFh. Unmapped pointers are table 00h, table 03h, tables above 08h and the gaps past each region's end.
- R6: A device-address byte matches when its upper seven bits equal the main address. That address is A2h when cfg_asel is 0 and cfg_slave_addr when cfg_asel is 1. Bit 0 is ignored, and dev_ack rises only while dev_vld is high.
- R7: Device address A0h selects the auxiliary device. There every pointer 00h–FFh asserts mem_cs bit 1 with offset equal to the pointer, and the table-select byte is neither read nor written.
- R8: After a device-address byte that matches neither device, strobes assert no mem_cs bit and no mem_we.
- R9: Each read or write strobe to a selected device advances the pointer by one, wrapping from FFh to 00h. A pointer byte (ptr_vld) loads it directly.
- R10: mem_we is high only during a write strobe to a mapped region. A read of a mapped region returns mem_rdata.
- R11: A new table-select value applies from the access right after the write that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dev_vld | input | 1 | Device-address byte present on dev_addr |
| dev_addr | input | 8 | Received device-address byte, bit 0 ignored |
| dev_ack | output | 1 | Device address matches main or auxiliary device |
| ptr_vld | input | 1 | Byte-address byte present on ptr_data |
| ptr_data | input | 8 | Byte address to load into the pointer |
| rd_stb | input | 1 | One-cycle read strobe for the byte at the pointer |
| wr_stb | input | 1 | One-cycle write strobe for the byte at the pointer |
| wr_data | input | 8 | Write data byte |
| cfg_asel | input | 1 | Main address from cfg_slave_addr when 1, default when 0 |
| cfg_slave_addr | input | 8 | Configured main device address |
| cfg_mask | input | 1 | Places the alarm-enable row in table 05h when 1 |
| mem_rdata | input | 8 | Read data from the selected storage region |
| mem_cs | output | 9 | One-hot region select, valid during a strobe |
| mem_off | output | 8 | Byte offset inside the selected region |
| mem_we | output | 1 | Write enable to the selected region |
| rd_data | output | 8 | Read data returned to the front end |

## Verification
The assertions assume that the front end never raises rd_stb and wr_stb in the same cycle. They also assume that dev_vld and ptr_vld come from the front end as single-cycle pulses, before the strobes of the same transaction. The directed stimulus drives at most one control input per cycle and changes inputs only on the falling clock edge. A change of cfg_mask or cfg_asel happens only between transactions, so each access decodes against one stable configuration.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
  localparam int ADDR_W = 8;
  typedef logic [ADDR_W-1:0] byte_t;

  localparam byte_t UPPER_BASE = 8'h80;
  localparam byte_t ALARM_BASE = 8'hF8;
  localparam int    T4_LEN     = 72;
  localparam int    LUT_LEN    = 36;
  localparam int    LUT_CNT    = 3;
  localparam byte_t T4_END     = byte_t'(int'(UPPER_BASE) + T4_LEN);
  localparam byte_t LUT_END    = byte_t'(int'(UPPER_BASE) + LUT_LEN);

  localparam byte_t TBL_GEN  = 8'h01;
  localparam byte_t TBL_CFG  = 8'h02;
  localparam byte_t TBL_MLUT = 8'h04;
  localparam byte_t TBL_ALT  = 8'h05;
  localparam byte_t TBL_LUT0 = 8'h06;

  localparam int RG_LOWER = 0;
  localparam int RG_AUX   = 1;
  localparam int RG_GEN   = 2;
  localparam int RG_ALARM = 3;
  localparam int RG_CFG   = 4;
  localparam int RG_MLUT  = 5;
  localparam int RG_LUT0  = 6;
  localparam int RG_NUM   = RG_LUT0 + LUT_CNT;

  localparam byte_t UNMAPPED_DATA = 8'hFF;
endpackage

// File: rtl/pmd_dev_match.sv
module pmd_dev_match
  import pmd_pkg::*;
#(
  parameter byte_t MAIN_DEF_ADDR = 8'hA2,
  parameter byte_t AUX_ADDR      = 8'hA0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dev_vld,
  input  byte_t dev_addr,
  input  logic  cfg_asel,
  input  byte_t cfg_slave_addr,
  output logic  dev_ack,
  output logic  sel_main,
  output logic  sel_aux
);
  byte_t main_addr;
  logic  hit_main, hit_aux;
  logic  sel_main_nx, sel_aux_nx;

  always_comb begin
    main_addr = cfg_asel ? cfg_slave_addr : MAIN_DEF_ADDR;
    hit_main  = (dev_addr[ADDR_W-1:1] == main_addr[ADDR_W-1:1]);
    hit_aux   = (dev_addr[ADDR_W-1:1] == AUX_ADDR[ADDR_W-1:1]) && !hit_main;
    dev_ack   = dev_vld && (hit_main || hit_aux);
  end

  always_comb begin
    sel_main_nx = sel_main;
    sel_aux_nx  = sel_aux;
    if (dev_vld) begin
      sel_main_nx = hit_main;
      sel_aux_nx  = hit_aux;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_main <= 1'b0;
      sel_aux  <= 1'b0;
    end else begin
      sel_main <= sel_main_nx;
      sel_aux  <= sel_aux_nx;
    end
  end

  AST_SINGLE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_main && sel_aux)); // R6
  AST_ACK_NEEDS_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> dev_vld); // R6
endmodule

// File: rtl/pmd_ctx_regs.sv
module pmd_ctx_regs
  import pmd_pkg::*;
#(
  parameter byte_t TSEL_RST = 8'h01
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ptr_vld,
  input  byte_t ptr_data,
  input  logic  acc,
  input  logic  tsel_wr,
  input  byte_t wr_data,
  output byte_t ptr,
  output byte_t tsel
);
  byte_t ptr_nx, tsel_nx;

  always_comb begin
    ptr_nx = ptr;
    if (ptr_vld) begin
      ptr_nx = ptr_data;
    end else if (acc) begin
      ptr_nx = ptr + 8'd1;
    end
  end

  always_comb begin
    tsel_nx = tsel;
    if (tsel_wr) begin
      tsel_nx = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      tsel <= TSEL_RST;
    end else begin
      ptr  <= ptr_nx;
      tsel <= tsel_nx;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !ptr_vld) |=> (ptr == $past(ptr) + 8'd1)); // R9
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_vld |=> (ptr == $past(ptr_data))); // R9
  AST_TSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tsel_wr |=> $stable(tsel)); // R2
endmodule

// File: rtl/pmd_page_decode.sv
module pmd_page_decode
  import pmd_pkg::*;
#(
  parameter byte_t TSEL_LOC = 8'h7F
) (
  input  logic              rst_n,
  input  logic              clk,
  input  logic              sel_main,
  input  logic              sel_aux,
  input  byte_t             ptr,
  input  byte_t             tsel,
  input  logic              cfg_mask,
  output logic [RG_NUM-1:0] rg,
  output byte_t             off,
  output logic              tsel_hit
);
  logic [LUT_CNT-1:0] lut_hit;
  logic               upper;

  assign upper = sel_main && ptr[ADDR_W-1];

  for (genvar g = 0; g < LUT_CNT; g++) begin : g_lut
    assign lut_hit[g] = upper && (tsel == byte_t'(int'(TBL_LUT0) + g)) && (ptr < LUT_END);
  end

  always_comb begin
    rg       = '0;
    off      = ptr;
    tsel_hit = 1'b0;
    if (sel_aux) begin
      rg[RG_AUX] = 1'b1;
    end else if (sel_main && (ptr == TSEL_LOC)) begin
      tsel_hit = 1'b1;
    end else if (sel_main && !ptr[ADDR_W-1]) begin
      rg[RG_LOWER] = 1'b1;
    end else if (upper) begin
      off = ptr - UPPER_BASE;
      unique case (tsel)
        TBL_GEN: begin
          if (ptr >= ALARM_BASE) begin
            if (!cfg_mask) begin
              rg[RG_ALARM] = 1'b1;
              off          = ptr - ALARM_BASE;
            end
          end else begin
            rg[RG_GEN] = 1'b1;
          end
        end
        TBL_CFG:  rg[RG_CFG] = 1'b1;
        TBL_MLUT: rg[RG_MLUT] = (ptr < T4_END);
        TBL_ALT: begin
          if ((ptr >= ALARM_BASE) && cfg_mask) begin
            rg[RG_ALARM] = 1'b1;
            off          = ptr - ALARM_BASE;
          end
        end
        default: begin
          for (int i = 0; i < LUT_CNT; i++) begin
            if (lut_hit[i]) rg[RG_LUT0 + i] = 1'b1;
          end
        end
      endcase
    end
  end

  AST_SINGLE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rg, tsel_hit})); // R5
  AST_LOWER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rg[RG_LOWER] |-> (!ptr[ADDR_W-1] && ptr != TSEL_LOC && sel_main)); // R1
  AST_IDLE_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_main || sel_aux) |-> (rg == '0 && !tsel_hit)); // R8
  AST_AUX_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
    rg[RG_AUX] |-> (sel_aux && off == ptr)); // R7
  AST_ALARM_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
    rg[RG_ALARM] |-> (ptr >= ALARM_BASE && off < 8'd8)); // R4
endmodule

// File: rtl/paged_map_decoder.sv
module paged_map_decoder
  import pmd_pkg::*;
#(
  parameter logic [7:0] MAIN_DEF_ADDR = 8'hA2,
  parameter logic [7:0] AUX_ADDR      = 8'hA0,
  parameter logic [7:0] TSEL_RST      = 8'h01,
  parameter logic [7:0] TSEL_LOC      = 8'h7F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        dev_vld,
  input  logic [7:0]  dev_addr,
  output logic        dev_ack,
  input  logic        ptr_vld,
  input  logic [7:0]  ptr_data,
  input  logic        rd_stb,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  input  logic        cfg_asel,
  input  logic [7:0]  cfg_slave_addr,
  input  logic        cfg_mask,
  input  logic [7:0]  mem_rdata,
  output logic [8:0]  mem_cs,
  output logic [7:0]  mem_off,
  output logic        mem_we,
  output logic [7:0]  rd_data
);
  logic              sel_main, sel_aux;
  byte_t             ptr, tsel;
  logic [RG_NUM-1:0] rg;
  logic              tsel_hit;
  logic              stb;

  assign stb = rd_stb || wr_stb;

  pmd_dev_match #(
    .MAIN_DEF_ADDR (MAIN_DEF_ADDR),
    .AUX_ADDR      (AUX_ADDR)
  ) dev_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dev_vld        (dev_vld),
    .dev_addr       (dev_addr),
    .cfg_asel       (cfg_asel),
    .cfg_slave_addr (cfg_slave_addr),
    .dev_ack        (dev_ack),
    .sel_main       (sel_main),
    .sel_aux        (sel_aux)
  );

  pmd_ctx_regs #(
    .TSEL_RST (TSEL_RST)
  ) ctx_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ptr_vld  (ptr_vld),
    .ptr_data (ptr_data),
    .acc      (stb && (sel_main || sel_aux)),
    .tsel_wr  (wr_stb && tsel_hit),
    .wr_data  (wr_data),
    .ptr      (ptr),
    .tsel     (tsel)
  );

  pmd_page_decode #(
    .TSEL_LOC (TSEL_LOC)
  ) dec_i (
    .rst_n    (rst_n),
    .clk      (clk),
    .sel_main (sel_main),
    .sel_aux  (sel_aux),
    .ptr      (ptr),
    .tsel     (tsel),
    .cfg_mask (cfg_mask),
    .rg       (rg),
    .off      (mem_off),
    .tsel_hit (tsel_hit)
  );

  always_comb begin
    mem_cs = stb ? rg : '0;
    mem_we = wr_stb && (rg != '0);
    if (tsel_hit) begin
      rd_data = tsel;
    end else if (rg != '0) begin
      rd_data = mem_rdata;
    end else begin
      rd_data = UNMAPPED_DATA;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb)); // R10
  AST_WE_MAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($onehot(mem_cs) && wr_stb)); // R10
  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !tsel_hit && mem_cs == '0) |-> (rd_data == 8'hFF)); // R5
  AST_TSEL_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    tsel_hit |-> (mem_cs == '0 && !mem_we)); // R2
endmodule

// File: tb/paged_map_decoder_tb_top.sv
module paged_map_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [8:0] CS_NONE  = 9'd0;
  localparam logic [8:0] CS_LOWER = 9'd1 << 0;
  localparam logic [8:0] CS_AUX   = 9'd1 << 1;
  localparam logic [8:0] CS_GEN   = 9'd1 << 2;
  localparam logic [8:0] CS_ALARM = 9'd1 << 3;
  localparam logic [8:0] CS_CFG   = 9'd1 << 4;
  localparam logic [8:0] CS_MLUT  = 9'd1 << 5;
  localparam logic [8:0] CS_LUT0  = 9'd1 << 6;
  localparam logic [8:0] CS_LUT1  = 9'd1 << 7;
  localparam logic [8:0] CS_LUT2  = 9'd1 << 8;
  localparam logic [7:0] MEMDAT   = 8'h5A;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       dev_vld, ptr_vld, rd_stb, wr_stb, cfg_asel, cfg_mask;
  logic [7:0] dev_addr, ptr_data, wr_data, cfg_slave_addr, mem_rdata;
  logic       dev_ack, mem_we;
  logic [8:0] mem_cs;
  logic [7:0] mem_off, rd_data;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  paged_map_decoder dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .dev_vld        (dev_vld),
    .dev_addr       (dev_addr),
    .dev_ack        (dev_ack),
    .ptr_vld        (ptr_vld),
    .ptr_data       (ptr_data),
    .rd_stb         (rd_stb),
    .wr_stb         (wr_stb),
    .wr_data        (wr_data),
    .cfg_asel       (cfg_asel),
    .cfg_slave_addr (cfg_slave_addr),
    .cfg_mask       (cfg_mask),
    .mem_rdata      (mem_rdata),
    .mem_cs         (mem_cs),
    .mem_off        (mem_off),
    .mem_we         (mem_we),
    .rd_data        (rd_data)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic select_dev(input logic [7:0] a, output logic ack);
    dev_vld = 1'b1; dev_addr = a;
    #1 ack = dev_ack;
    @(negedge clk);
    dev_vld = 1'b0;
  endtask

  task automatic set_ptr(input logic [7:0] a);
    ptr_vld = 1'b1; ptr_data = a;
    @(negedge clk);
    ptr_vld = 1'b0;
  endtask

  task automatic access(input logic wr, input logic [7:0] d, output logic [8:0] cs,
                        output logic [7:0] off, output logic we, output logic [7:0] rd);
    rd_stb = !wr; wr_stb = wr; wr_data = d;
    #1;
    cs = mem_cs; off = mem_off; we = mem_we; rd = rd_data;
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [7:0] tbl, input logic [7:0] a,
                       input logic [8:0] exp_cs, input logic [7:0] exp_off);
    logic [8:0] cs; logic [7:0] off, rd; logic we, ack;
    select_dev(8'hA2, ack);
    set_ptr(8'h7F);
    access(1'b1, tbl, cs, off, we, rd);
    set_ptr(a);
    access(1'b0, 8'h00, cs, off, we, rd);
    chk({tag, " cs"}, 16'(cs), 16'(exp_cs));
    if (exp_cs != CS_NONE) chk({tag, " off"}, 16'(off), 16'(exp_off));
    chk({tag, " rd"}, 16'(rd), (exp_cs == CS_NONE) ? 16'h00FF : 16'(MEMDAT));
  endtask

  task automatic t_reset;
    logic [8:0] cs; logic [7:0] off, rd; logic we, ack;
    chk("R8 reset dev_ack", 16'(dev_ack), 16'd0);
    rd_stb = 1'b1;
    #1 chk("R8 reset no cs before select", 16'(mem_cs), 16'd0);
    @(negedge clk);
    rd_stb = 1'b0;
    select_dev(8'hA2, ack);
    set_ptr(8'h7F);
    access(1'b0, 8'h00, cs, off, we, rd);
    chk("R2 reset table select", 16'(rd), 16'h0001);
    chk("R2 read no cs", 16'(cs), 16'(CS_NONE));
  endtask

  task automatic t_lower;
    logic [8:0] cs; logic [7:0] off, rd; logic we, ack;
    select_dev(8'hA2, ack);
    set_ptr(8'h10);
    access(1'b0, 8'h00, cs, off, we, rd);
    chk("R1 lower cs", 16'(cs), 16'(CS_LOWER));
    chk("R1 lower off", 16'(off), 16'h0010);
    chk("R10 lower rd", 16'(rd), 16'(MEMDAT));
    set_ptr(8'h7F);
    access(1'b1, 8'h04, cs, off, we, rd);
    chk("R2 write no cs", 16'(cs), 16'(CS_NONE));
    chk("R2 write no we", 16'(we), 16'd0);
    set_ptr(8'h7E);
    access(1'b1, 8'h11, cs, off, we, rd);
    chk("R1 lower with table 04 cs", 16'(cs), 16'(CS_LOWER));
    chk("R1 lower with table 04 off", 16'(off), 16'h007E);
    chk("R10 lower write we", 16'(we), 16'd1);
  endtask

  task automatic t_tsel_timing;
    logic [8:0] cs; logic [7:0] off, rd; logic we;
    set_ptr(8'h7F);
    access(1'b1, 8'h07, cs, off, we, rd);
    access(1'b0, 8'h00, cs, off, we, rd);
    chk("R11 next access uses table 07", 16'(cs), 16'(CS_LUT1));
    chk("R9 pointer advanced to 80", 16'(off), 16'h0000);
  endtask

  task automatic t_tables;
    cfg_mask = 1'b0;
    probe("R3 t01 80", 8'h01, 8'h80, CS_GEN, 8'h00);
    probe("R3 t01 F7", 8'h01, 8'hF7, CS_GEN, 8'h77);
    probe("R3 t02 8C", 8'h02, 8'h8C, CS_CFG, 8'h0C);
    probe("R3 t02 FF", 8'h02, 8'hFF, CS_CFG, 8'h7F);
    probe("R3 t04 C7", 8'h04, 8'hC7, CS_MLUT, 8'h47);
    probe("R3 t04 C8 gap", 8'h04, 8'hC8, CS_NONE, 8'h00);
    probe("R3 t06 A3", 8'h06, 8'hA3, CS_LUT0, 8'h23);
    probe("R3 t07 90", 8'h07, 8'h90, CS_LUT1, 8'h10);
    probe("R3 t08 80", 8'h08, 8'h80, CS_LUT2, 8'h00);
    probe("R3 t08 A4 gap", 8'h08, 8'hA4, CS_NONE, 8'h00);
  endtask

  task automatic t_alarm;
    cfg_mask = 1'b0;
    probe("R4 mask0 t01 F8", 8'h01, 8'hF8, CS_ALARM, 8'h00);
    probe("R4 mask0 t05 FF", 8'h05, 8'hFF, CS_NONE, 8'h00);
    cfg_mask = 1'b1;
    probe("R4 mask1 t05 FB", 8'h05, 8'hFB, CS_ALARM, 8'h03);
    probe("R4 mask1 t01 FF", 8'h01, 8'hFF, CS_NONE, 8'h00);
    probe("R4 mask1 t01 80", 8'h01, 8'h80, CS_GEN, 8'h00);
    cfg_mask = 1'b0;
  endtask

  task automatic t_unmapped;
    logic [8:0] cs; logic [7:0] off, rd; logic we;
    probe("R5 table 00", 8'h00, 8'h80, CS_NONE, 8'h00);
    probe("R5 table 03", 8'h03, 8'h90, CS_NONE, 8'h00);
    probe("R5 table 09", 8'h09, 8'h80, CS_NONE, 8'h00);
    set_ptr(8'hB0);
    access(1'b1, 8'h77, cs, off, we, rd);
    chk("R5 unmapped write cs", 16'(cs), 16'(CS_NONE));
    chk("R5 unmapped write we", 16'(we), 16'd0);
  endtask

  task automatic t_device;
    logic [8:0] cs; logic [7:0] off, rd; logic we, ack;
    cfg_asel = 1'b0;
    select_dev(8'hA2, ack); chk("R6 default A2 ack", 16'(ack), 16'd1);
    select_dev(8'hA3, ack); chk("R6 bit0 ignored ack", 16'(ack), 16'd1);
    select_dev(8'hA4, ack); chk("R6 A4 no ack", 16'(ack), 16'd0);
    set_ptr(8'h10);
    access(1'b1, 8'h01, cs, off, we, rd);
    chk("R8 unselected cs", 16'(cs), 16'(CS_NONE));
    chk("R8 unselected we", 16'(we), 16'd0);
    cfg_asel = 1'b1; cfg_slave_addr = 8'hB0;
    select_dev(8'hB0, ack); chk("R6 configured B0 ack", 16'(ack), 16'd1);
    set_ptr(8'h20);
    access(1'b0, 8'h00, cs, off, we, rd);
    chk("R6 configured device lower cs", 16'(cs), 16'(CS_LOWER));
    select_dev(8'hA2, ack); chk("R6 A2 not answered", 16'(ack), 16'd0);
    cfg_asel = 1'b0;
  endtask

  task automatic t_aux;
    logic [8:0] cs; logic [7:0] off, rd; logic we, ack;
    select_dev(8'hA2, ack);
    set_ptr(8'h7F);
    access(1'b1, 8'h02, cs, off, we, rd);
    select_dev(8'hA0, ack); chk("R7 aux ack", 16'(ack), 16'd1);
    set_ptr(8'h7F);
    access(1'b1, 8'h33, cs, off, we, rd);
    chk("R7 aux 7F cs", 16'(cs), 16'(CS_AUX));
    chk("R7 aux 7F off", 16'(off), 16'h007F);
    chk("R7 aux 7F we", 16'(we), 16'd1);
    select_dev(8'hA2, ack);
    set_ptr(8'h7F);
    access(1'b0, 8'h00, cs, off, we, rd);
    chk("R7 table select untouched", 16'(rd), 16'h0002);
  endtask

  task automatic t_wrap;
    logic [8:0] cs; logic [7:0] off, rd; logic we, ack;
    select_dev(8'hA0, ack);
    set_ptr(8'hFE);
    access(1'b0, 8'h00, cs, off, we, rd); chk("R9 off FE", 16'(off), 16'h00FE);
    access(1'b0, 8'h00, cs, off, we, rd); chk("R9 off FF", 16'(off), 16'h00FF);
    access(1'b0, 8'h00, cs, off, we, rd); chk("R9 wrap 00", 16'(off), 16'h0000);
    chk("R7 aux cs after wrap", 16'(cs), 16'(CS_AUX));
  endtask

  initial begin
    rst_n = 1'b0; dev_vld = 1'b0; ptr_vld = 1'b0; rd_stb = 1'b0; wr_stb = 1'b0;
    dev_addr = '0; ptr_data = '0; wr_data = '0; cfg_asel = 1'b0; cfg_mask = 1'b0;
    cfg_slave_addr = 8'hA2; mem_rdata = MEMDAT;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_lower;
    t_tsel_timing;
    t_tables;
    t_alarm;
    t_unmapped;
    t_device;
    t_aux;
    t_wrap;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule